// File: doc/BRIEF.md
# Performance Level Request Selector

This block chooses the performance level index handed to the voltage scaling logic and to the clock scaling logic. Software programs one control word with a global enable, a pulse-width DVS mode, a boost override, a debug mode and a handshake enable, plus a 3-bit boost level. From that word and three live inputs (a software-requested level, a boost request line and the current PWM phase), the block produces a registered voltage target, a registered clock target and a power request line.

The boost override lets an urgent event raise performance to a programmed level. That level can be set below the top level so the chip does not overdrive on every event. When the handshake is enabled, entering and leaving boost goes through a request/acknowledge exchange with the scaling logic. In debug mode the voltage target stays at the top level, and only the clock target shows the level that was computed.

Top module: `perf_level_selector`

## Requirements
- R1: The control word is written through `cfg_wr_en`/`cfg_wdata` and read on `cfg_rdata` in the next cycle. Bit 0 is the enable, bit 1 is PWM mode, bit 2 is the boost override, bit 3 is debug, bit 4 is the handshake enable, and bits [7:5] hold the boost level.
- R2: After reset, `cfg_rdata` reads 0x000000E0 (all enables 0, boost level 7), both targets are 7, and `pwr_req` and `hs_req` are 0.
- R3: Writes to bits [31:8] are ignored, and those bits always read 0.
- R4: While the enable bit is 0, both targets are 7 and `pwr_req` is 0, whatever the other inputs are.
- R5: When enabled, with the override on and `boost_irq` high, boost is active. Without the handshake, the targets then take the programmed boost level.
- R6: When enabled with PWM mode set, `pwr_req` is 1. Unless boost is active, the level is 7 when `pwm_state` is 1 and 0 when it is 0.
- R7: When enabled with neither boost nor PWM mode active, the level equals `sw_level`.
- R8: Priority runs disable, then boost, then PWM mode, then software level.
- R9: With enable and debug both set, `tgt_volt_idx` is 7 and only `tgt_clk_idx` carries the computed level.
- R10: With the handshake enabled, a boost request raises `hs_req` one cycle later. The previous level is held until `hs_ack` is seen high, and the boost level appears on the targets one cycle after that.
- R11: When the boost request goes away in handshake mode, `hs_req` drops. The boost level stays until `hs_ack` is seen low, and the previous level returns one cycle after that.
- R12: With the handshake disabled, `hs_req` stays 0 and boost takes effect with no exchange.
- R13: All targets and `pwr_req` are registered. A change of input or configuration shows on them after exactly one clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Control word write strobe |
| cfg_wdata | input | 32 | Control word write data |
| cfg_rdata | output | 32 | Control word read data |
| sw_level | input | 3 | Software-requested level |
| boost_irq | input | 1 | Boost request event line |
| pwm_state | input | 1 | Current PWM phase (1 = high) |
| hs_ack | input | 1 | Handshake acknowledge from the scaling logic |
| hs_req | output | 1 | Handshake request to the scaling logic |
| tgt_volt_idx | output | 3 | Voltage target level index |
| tgt_clk_idx | output | 3 | Clock target level index |
| pwr_req | output | 1 | Power request in PWM mode |

## Verification
The handshake assertions assume that the acknowledge follows the request. `hs_ack` rises only while `hs_req` is high, and falls only while `hs_req` is low. The bench's acknowledge responder follows that rule with random delays. The bench rewrites the control word only while both `hs_req` and `hs_ack` are low, so the handshake enable never flips in the middle of an exchange. Other inputs change freely each cycle and are compared against a cycle model of the selection rules.

// File: rtl/perf_sel_pkg.sv
package perf_sel_pkg;
    parameter int LVL_W = 3;
    localparam int CFG_BITS = 5 + LVL_W;
    localparam logic [LVL_W-1:0] LVL_MAX = '1;
    localparam logic [LVL_W-1:0] LVL_MIN = '0;

    // Field order matches bit positions of the control word, MSB first.
    typedef struct packed {
        logic [LVL_W-1:0] boost_lvl;  // [7:5]
        logic             hs_en;      // [4]
        logic             dbg;        // [3]
        logic             ovr;        // [2]
        logic             pwm;        // [1]
        logic             en;         // [0]
    } cfg_t;

    localparam cfg_t CFG_RST = '{boost_lvl: LVL_MAX, hs_en: 1'b0, dbg: 1'b0,
                                 ovr: 1'b0, pwm: 1'b0, en: 1'b0};

    typedef enum logic [1:0] {
        HS_IDLE     = 2'd0,
        HS_WAIT_IN  = 2'd1,
        HS_ACTIVE   = 2'd2,
        HS_WAIT_OUT = 2'd3
    } hs_state_e;

    typedef struct packed {
        logic [LVL_W-1:0] volt;
        logic [LVL_W-1:0] clk;
        logic             pwr;
    } lvl_out_t;
endpackage

// File: rtl/perf_cfg_reg.sv
module perf_cfg_reg
    import perf_sel_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output cfg_t              cfg
);
    localparam int PAD_W = DATA_W - CFG_BITS;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            cfg_d = cfg_t'(wdata[CFG_BITS-1:0]);  // upper bits dropped
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= CFG_RST;
        else        cfg_q <= cfg_d;
    end

    assign cfg   = cfg_q;
    assign rdata = {{PAD_W{1'b0}}, cfg_q};

    // R1: a write is visible on the read port one cycle later
    p_wr_readback_r1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> rdata[CFG_BITS-1:0] == $past(wdata[CFG_BITS-1:0]));
endmodule

// File: rtl/perf_boost_hs.sv
module perf_boost_hs
    import perf_sel_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hs_en,
    input  logic boost_want,
    input  logic hs_ack,
    output logic boost_on,
    output logic hs_req
);
    hs_state_e st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!hs_en) begin
            st_d = HS_IDLE;
        end else begin
            unique case (st_q)
                HS_IDLE:     if (boost_want) st_d = HS_WAIT_IN;
                HS_WAIT_IN:  if (hs_ack)     st_d = HS_ACTIVE;
                HS_ACTIVE:   if (!boost_want) st_d = HS_WAIT_OUT;
                HS_WAIT_OUT: if (!hs_ack)    st_d = HS_IDLE;
                default:                     st_d = HS_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= HS_IDLE;
        else        st_q <= st_d;
    end

    assign hs_req   = (st_q == HS_WAIT_IN) || (st_q == HS_ACTIVE);
    assign boost_on = hs_en ? ((st_q == HS_ACTIVE) || (st_q == HS_WAIT_OUT))
                            : boost_want;

    // R12: no request while the handshake is disabled
    p_hs_off_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !hs_en |=> !hs_req);
    // R10: request held until acknowledged
    p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_en && hs_req && !hs_ack) |=> hs_req);
    // R10: no boost before the acknowledge
    p_no_early_boost_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_en && hs_req && !hs_ack) |-> !boost_on);
    // R11: no new request until the acknowledge has dropped
    p_exit_wait_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_en && !hs_req && hs_ack) |=> !hs_req);
endmodule

// File: rtl/perf_level_pick.sv
module perf_level_pick
    import perf_sel_pkg::*;
(
    input  cfg_t             cfg,
    input  logic             boost_on,
    input  logic             pwm_state,
    input  logic [LVL_W-1:0] sw_level,
    output lvl_out_t         nxt
);
    logic [LVL_W-1:0] lvl;

    always_comb begin
        // Priority: boost, then PWM, then software request
        if (boost_on)     lvl = cfg.boost_lvl;
        else if (cfg.pwm) lvl = pwm_state ? LVL_MAX : LVL_MIN;
        else              lvl = sw_level;

        if (!cfg.en) begin
            nxt.volt = LVL_MAX;
            nxt.clk  = LVL_MAX;
            nxt.pwr  = 1'b0;
        end else begin
            nxt.volt = cfg.dbg ? LVL_MAX : lvl;
            nxt.clk  = lvl;
            nxt.pwr  = cfg.pwm;
        end
    end
endmodule

// File: rtl/perf_level_selector.sv
module perf_level_selector
    import perf_sel_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [DATA_W-1:0] cfg_rdata,
    input  logic [LVL_W-1:0]  sw_level,
    input  logic              boost_irq,
    input  logic              pwm_state,
    input  logic              hs_ack,
    output logic              hs_req,
    output logic [LVL_W-1:0]  tgt_volt_idx,
    output logic [LVL_W-1:0]  tgt_clk_idx,
    output logic              pwr_req
);
    localparam lvl_out_t OUT_RST = '{volt: LVL_MAX, clk: LVL_MAX, pwr: 1'b0};

    cfg_t     cfg;
    logic     boost_want;
    logic     boost_on;
    lvl_out_t out_d, out_q;

    perf_cfg_reg #(.DATA_W(DATA_W)) u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (cfg_wr_en),
        .wdata (cfg_wdata),
        .rdata (cfg_rdata),
        .cfg   (cfg)
    );

    assign boost_want = cfg.en && cfg.ovr && boost_irq;

    perf_boost_hs u_hs (
        .clk        (clk),
        .rst_n      (rst_n),
        .hs_en      (cfg.hs_en),
        .boost_want (boost_want),
        .hs_ack     (hs_ack),
        .boost_on   (boost_on),
        .hs_req     (hs_req)
    );

    perf_level_pick u_pick (
        .cfg       (cfg),
        .boost_on  (boost_on),
        .pwm_state (pwm_state),
        .sw_level  (sw_level),
        .nxt       (out_d)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= OUT_RST;
        else        out_q <= out_d;
    end

    assign tgt_volt_idx = out_q.volt;
    assign tgt_clk_idx  = out_q.clk;
    assign pwr_req      = out_q.pwr;

    // R4: disabled block requests the top level on both targets
    p_disabled_max_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg.en |=> (tgt_volt_idx == LVL_MAX && tgt_clk_idx == LVL_MAX && !pwr_req));
    // R9: debug pins the voltage target at the top
    p_debug_volt_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.en && cfg.dbg) |=> tgt_volt_idx == LVL_MAX);
    // R6: PWM mode without boost gives only the two extreme levels
    p_pwm_levels_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.en && cfg.pwm && !boost_on) |=>
            (tgt_clk_idx == LVL_MAX || tgt_clk_idx == LVL_MIN));
    // R5: active boost drives the programmed level onto the clock target
    p_boost_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.en && boost_on) |=> tgt_clk_idx == $past(cfg.boost_lvl));
endmodule

// File: tb/tb_perf_level_selector.sv
module tb_perf_level_selector;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic [2:0]  sw_level = '0;
    logic        boost_irq = 1'b0;
    logic        pwm_state = 1'b0;
    logic        hs_ack = 1'b0;
    logic        hs_req;
    logic [2:0]  tgt_volt_idx, tgt_clk_idx;
    logic        pwr_req;

    int n_tests = 0;
    int n_fail  = 0;

    // reference model state
    logic [7:0] m_cfg = 8'hE0;
    logic [1:0] m_st  = 2'd0;
    logic [2:0] e_volt = 3'd7, e_clk = 3'd7;
    logic       e_pwr = 1'b0, e_hsreq = 1'b0;
    string      tag_lvl = "R2", tag_hs = "R2";

    always #4 clk = ~clk;  // 125 MHz

    perf_level_selector dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .sw_level(sw_level), .boost_irq(boost_irq),
        .pwm_state(pwm_state), .hs_ack(hs_ack), .hs_req(hs_req),
        .tgt_volt_idx(tgt_volt_idx), .tgt_clk_idx(tgt_clk_idx), .pwr_req(pwr_req)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h t=%0t", tag, what, act, exp, $time);
        end
    endtask

    // Level from the priority rules (R5..R8), before enable/debug
    function automatic logic [2:0] ref_level(input logic [7:0] c, input logic boost,
                                             input logic pw, input logic [2:0] sw);
        if (boost)     return c[7:5];
        else if (c[1]) return pw ? 3'd7 : 3'd0;
        else           return sw;
    endfunction

    // One clock edge of the reference model
    task automatic model_edge();
        logic       en   = m_cfg[0];
        logic       hs   = m_cfg[4];
        logic       want = m_cfg[0] & m_cfg[2] & boost_irq;
        logic       boost;
        logic [2:0] lvl;
        logic [1:0] nst;
        boost = hs ? (m_st >= 2'd2) : want;
        lvl   = ref_level(m_cfg, boost, pwm_state, sw_level);
        if (!en) begin
            e_volt = 3'd7; e_clk = 3'd7; e_pwr = 1'b0; tag_lvl = "R4";
        end else begin
            e_clk  = lvl;
            e_volt = m_cfg[3] ? 3'd7 : lvl;
            e_pwr  = m_cfg[1];
            if (boost && m_cfg[1])  tag_lvl = "R8";
            else if (boost)         tag_lvl = hs ? "R10" : "R5";
            else if (m_cfg[1])      tag_lvl = "R6";
            else                    tag_lvl = "R7";
            if (hs && m_st == 2'd3) tag_lvl = "R11";
        end
        if (!hs) nst = 2'd0;
        else case (m_st)
            2'd0: nst = want ? 2'd1 : 2'd0;
            2'd1: nst = hs_ack ? 2'd2 : 2'd1;
            2'd2: nst = want ? 2'd2 : 2'd3;
            default: nst = hs_ack ? 2'd3 : 2'd0;
        endcase
        tag_hs  = hs ? (m_st >= 2'd2 ? "R11" : "R10") : "R12";
        m_st    = nst;
        e_hsreq = (nst == 2'd1) || (nst == 2'd2);
        if (cfg_wr_en) m_cfg = cfg_wdata[7:0];
    endtask

    task automatic compare();
        chk(tag_lvl, "tgt_clk_idx", 32'(tgt_clk_idx), 32'(e_clk));
        chk(m_cfg[3] && m_cfg[0] ? "R9" : tag_lvl, "tgt_volt_idx",
            32'(tgt_volt_idx), 32'(e_volt));
        chk(e_pwr ? "R6" : tag_lvl, "pwr_req", 32'(pwr_req), 32'(e_pwr));
        chk(tag_hs, "hs_req", 32'(hs_req), 32'(e_hsreq));
        chk("R1", "cfg_rdata", cfg_rdata, {24'h0, m_cfg});
    endtask

    // Called at a negedge: drive, take one edge, check at the next negedge (R13)
    task automatic step(input logic wr, input logic [31:0] wd, input logic [2:0] sw,
                        input logic irq, input logic pw, input logic ack);
        cfg_wr_en = wr; cfg_wdata = wd; sw_level = sw;
        boost_irq = irq; pwm_state = pw; hs_ack = ack;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare();
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        void'($urandom(32'h5EED_0107));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R2: reset state
        chk("R2", "cfg_rdata", cfg_rdata, 32'h0000_00E0);
        chk("R2", "tgt_volt_idx", 32'(tgt_volt_idx), 32'd7);
        chk("R2", "tgt_clk_idx", 32'(tgt_clk_idx), 32'd7);
        chk("R2", "pwr_req", 32'(pwr_req), 32'd0);
        chk("R2", "hs_req", 32'(hs_req), 32'd0);

        // R4: disabled, software level ignored
        step(1'b0, 32'h0, 3'd2, 1'b1, 1'b0, 1'b0);
        chk("R4", "disabled clk target", 32'(tgt_clk_idx), 32'd7);
        // R3: reserved bits dropped
        step(1'b1, 32'hFFFF_FFFF, 3'd2, 1'b0, 1'b0, 1'b0);
        chk("R3", "reserved readback", cfg_rdata, 32'h0000_00FF);
        // enable only, software level
        step(1'b1, 32'h0000_0001, 3'd3, 1'b0, 1'b0, 1'b0);
        step(1'b0, 32'h0, 3'd3, 1'b0, 1'b0, 1'b0);
        chk("R7", "software level", 32'(tgt_clk_idx), 32'd3);
        // R13: no change before the edge
        sw_level = 3'd6;
        #1;
        chk("R13", "clk target before edge", 32'(tgt_clk_idx), 32'd3);
        step(1'b0, 32'h0, 3'd6, 1'b0, 1'b0, 1'b0);
        chk("R13", "clk target after edge", 32'(tgt_clk_idx), 32'd6);

        // Handshake boost: en|ovr|hs, boost level 5
        step(1'b1, 32'h0000_00B5, 3'd3, 1'b0, 1'b0, 1'b0);
        step(1'b0, 32'h0, 3'd3, 1'b1, 1'b0, 1'b0);
        chk("R10", "hs_req after request", 32'(hs_req), 32'd1);
        step(1'b0, 32'h0, 3'd3, 1'b1, 1'b0, 1'b0);
        step(1'b0, 32'h0, 3'd3, 1'b1, 1'b0, 1'b0);
        chk("R10", "level held before ack", 32'(tgt_clk_idx), 32'd3);
        step(1'b0, 32'h0, 3'd3, 1'b1, 1'b0, 1'b1);
        step(1'b0, 32'h0, 3'd3, 1'b1, 1'b0, 1'b1);
        chk("R10", "boost level after ack", 32'(tgt_clk_idx), 32'd5);
        step(1'b0, 32'h0, 3'd3, 1'b0, 1'b0, 1'b1);
        step(1'b0, 32'h0, 3'd3, 1'b0, 1'b0, 1'b1);
        chk("R11", "hs_req dropped", 32'(hs_req), 32'd0);
        chk("R11", "boost held until ack low", 32'(tgt_clk_idx), 32'd5);
        step(1'b0, 32'h0, 3'd3, 1'b0, 1'b0, 1'b0);
        step(1'b0, 32'h0, 3'd3, 1'b0, 1'b0, 1'b0);
        chk("R11", "level restored", 32'(tgt_clk_idx), 32'd3);

        // No handshake: en|pwm|ovr|dbg, boost level 5
        step(1'b1, 32'h0000_00AF, 3'd3, 1'b0, 1'b1, 1'b0);
        step(1'b0, 32'h0, 3'd3, 1'b1, 1'b1, 1'b0);
        chk("R12", "hs_req quiet", 32'(hs_req), 32'd0);
        step(1'b0, 32'h0, 3'd3, 1'b1, 1'b0, 1'b0);
        chk("R8", "boost over PWM", 32'(tgt_clk_idx), 32'd5);
        chk("R9", "debug volt", 32'(tgt_volt_idx), 32'd7);
        step(1'b0, 32'h0, 3'd3, 1'b0, 1'b0, 1'b0);
        chk("R6", "PWM low level", 32'(tgt_clk_idx), 32'd0);
        chk("R6", "pwr_req", 32'(pwr_req), 32'd1);

        // Constrained random phase
        for (int i = 0; i < 4000; i++) begin
            logic        wr  = 1'b0;
            logic [31:0] wd  = $urandom;
            logic        irq = boost_irq;
            logic        ack = hs_ack;
            if (!hs_req && !hs_ack && ($urandom % 16 == 0)) begin
                wr = 1'b1;
                wd[0] = ($urandom % 5 != 0);
                wd[2] = ($urandom % 3 != 0);
            end
            if ($urandom % 6 == 0) irq = ~irq;
            if (hs_req && !hs_ack && ($urandom % 3 == 0)) ack = 1'b1;
            if (!hs_req && hs_ack && ($urandom % 3 == 0)) ack = 1'b0;
            step(wr, wd, 3'($urandom), irq, 1'($urandom), ack);
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule